// File: doc/BRIEF.md
# Configurable mesh route selector

This block belongs in the network interface and routers of a two-dimensional mesh network-on-chip. When a packet is injected, the block decides whether the packet travels along X first and then Y, or along Y first and then X. The decision is a single route bit. The block stamps that bit, together with a matching virtual-channel index, into the header. Keeping the two path types on separate virtual channels is what keeps a mesh with mixed XY and YX traffic free of deadlock.

The policy is chosen at run time from five modes:
- fixed XY;
- alternation on every packet;
- a weighted coin that draws from an on-chip LFSR;
- the parity of the source and destination IDs;
- a per-destination bit held in a writable table.

The last two modes give every source-destination pair one fixed path, so packets of a pair stay in order.

At each hop a combinational port selector reads the current coordinates, the destination coordinates and the route bit, and picks the output port. Node IDs are `{y, x}`: the X coordinate sits in the low `XW` bits and the Y coordinate in the high `YW` bits.

Top module: `mesh_route_sel`

## Requirements
- R1: When `cfg_we_i` is high at a clock edge, `cfg_mode_i` and `cfg_weight_i` are registered. Reset gives mode 0 and weight 0. An injection in the same cycle as a configuration write uses the previous configuration.
- R2: `hdr_valid_o` is high exactly in the cycle after a cycle with `inj_valid_i` high. The route and VC fields are registered on that same edge and hold until the next injection.
- R3: Route bit 0 means XY and 1 means YX. `hdr_vc_o` always equals the route bit, so XY packets use VC 0 and YX packets use VC 1.
- R4: Mode 0 (fixed) gives route 0 for every packet.
- R5: Mode 1 (alternate) uses a 1-bit state. Reset sets it to 0. Each mode-1 injection takes the state as its route and then flips it. Injections in other modes leave the state unchanged.
- R6: Mode 2 (weighted) compares an 8-bit LFSR sample r with the weight C and gives route 0 when r < C, otherwise route 1. The LFSR resets to 8'h01 and steps as next = {r[6:0], r[7]^r[5]^r[4]^r[3]}. It steps only after a mode-2 injection, so a weight of 0 always gives route 1.
- R7: Mode 3 (pair parity) gives route = XOR-reduction of (`src_id_i` ^ `inj_dst_i`).
- R8: Mode 4 (table) gives route = the table bit indexed by `inj_dst_i`. The table has one bit per node and resets to all 0. A write through `tbl_we_i`/`tbl_addr_i`/`tbl_data_i` takes effect at the clock edge, so an injection in the same cycle reads the old bit.
- R9: With route 0, `hop_port_o` is EAST(1) if dst x > cur x and WEST(2) if dst x < cur x. Once x matches, it is NORTH(3) if dst y > cur y and SOUTH(4) if dst y < cur y.
- R10: With route 1, the Y comparison (NORTH/SOUTH) is applied first and the X comparison (EAST/WEST) only once y matches.
- R11: `hop_port_o` is LOCAL(0) exactly when the current and destination IDs are equal, for either route bit.
- R12: Mode codes 5 to 7 behave as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 3 | Routing mode code |
| cfg_weight_i | input | WW | XY weight C |
| src_id_i | input | XW+YW | ID of the local node |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | XW+YW | Table entry (destination ID) |
| tbl_data_i | input | 1 | Table route bit |
| inj_valid_i | input | 1 | Packet injected this cycle |
| inj_dst_i | input | XW+YW | Destination ID of injected packet |
| hdr_valid_o | output | 1 | Header fields valid |
| hdr_route_o | output | 1 | Route bit for header |
| hdr_vc_o | output | 1 | Virtual-channel index for header |
| hop_cur_i | input | XW+YW | ID of the router doing the hop |
| hop_dst_i | input | XW+YW | Destination ID from header |
| hop_route_i | input | 1 | Route bit from header |
| hop_port_o | output | 3 | Selected output port |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is a table write and a table-mode injection. The bench writes a 1 to the very entry that a simultaneous injection looks up. It expects the header to carry the old 0, and a second injection to that destination to carry the new 1.

The second pair is a configuration write and an injection. The bench switches the mode from fixed to alternate on the same edge as an injection. It expects the fixed result, and expects the alternation state to stay at 0 for the next packet.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;

  typedef enum logic [2:0] {
    MODE_XY     = 3'd0,
    MODE_TOGGLE = 3'd1,
    MODE_WEIGHT = 3'd2,
    MODE_PARITY = 3'd3,
    MODE_TABLE  = 3'd4
  } route_mode_e;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } hop_port_e;

endpackage

// File: rtl/route_lfsr.sv
module route_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] rnd_o
);

  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= SEED;
    else if (step_i) q <= {q[W-2:0], ^(q & TAPS)};
  end

  assign rnd_o = q;

  // R6
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q != '0);

endmodule

// File: rtl/route_table.sv
module route_table #(
  parameter int IDW = 4,
  localparam int NODES = 1 << IDW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [IDW-1:0] waddr_i,
  input  logic           wdata_i,
  input  logic [IDW-1:0] raddr_i,
  output logic           rdata_o
);

  logic [NODES-1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bits_q <= '0;
    else if (we_i) bits_q[waddr_i] <= wdata_i;
  end

  // read sees the value before a same-cycle write
  assign rdata_o = bits_q[raddr_i];

  // R8
  tbl_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> bits_q[$past(waddr_i)] == $past(wdata_i));

endmodule

// File: rtl/route_hop.sv
module route_hop
  import mesh_route_pkg::*;
#(
  parameter int XW = 2,
  parameter int YW = 2,
  localparam int IDW = XW + YW
) (
  input  logic [IDW-1:0] cur_i,
  input  logic [IDW-1:0] dst_i,
  input  logic           route_i,
  output hop_port_e      port_o
);

  logic [XW-1:0] cx, dx;
  logic [YW-1:0] cy, dy;
  hop_port_e     x_port, y_port;

  assign cx = cur_i[XW-1:0];
  assign dx = dst_i[XW-1:0];
  assign cy = cur_i[IDW-1:XW];
  assign dy = dst_i[IDW-1:XW];

  assign x_port = (dx > cx) ? PORT_EAST  : PORT_WEST;
  assign y_port = (dy > cy) ? PORT_NORTH : PORT_SOUTH;

  always_comb begin
    if (cx == dx && cy == dy) port_o = PORT_LOCAL;
    else if (!route_i)        port_o = (cx != dx) ? x_port : y_port;
    else                      port_o = (cy != dy) ? y_port : x_port;
  end

  always_comb begin
    // R11
    local_port_chk: assert ((port_o == PORT_LOCAL) == (cur_i == dst_i));
    // R9
    xy_order_chk: assert (route_i || cx == dx ||
                          port_o == PORT_EAST || port_o == PORT_WEST);
    // R10
    yx_order_chk: assert (!route_i || cy == dy ||
                          port_o == PORT_NORTH || port_o == PORT_SOUTH);
  end

endmodule

// File: rtl/mesh_route_sel.sv
module mesh_route_sel
  import mesh_route_pkg::*;
#(
  parameter int XW = 2,
  parameter int YW = 2,
  parameter int WW = 8,
  localparam int IDW = XW + YW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [2:0]     cfg_mode_i,
  input  logic [WW-1:0]  cfg_weight_i,
  input  logic [IDW-1:0] src_id_i,
  input  logic           tbl_we_i,
  input  logic [IDW-1:0] tbl_addr_i,
  input  logic           tbl_data_i,
  input  logic           inj_valid_i,
  input  logic [IDW-1:0] inj_dst_i,
  output logic           hdr_valid_o,
  output logic           hdr_route_o,
  output logic           hdr_vc_o,
  input  logic [IDW-1:0] hop_cur_i,
  input  logic [IDW-1:0] hop_dst_i,
  input  logic           hop_route_i,
  output logic [2:0]     hop_port_o
);

  logic [2:0]    mode_q;
  logic [WW-1:0] weight_q;
  logic          tog_q;
  logic [WW-1:0] rnd;
  logic          tbl_bit;
  logic          route_d;
  logic          route_q;
  logic          valid_q;
  logic          lfsr_step;
  hop_port_e     hop_port;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_XY;
      weight_q <= '0;
    end else if (cfg_we_i) begin
      mode_q   <= cfg_mode_i;
      weight_q <= cfg_weight_i;
    end
  end

  assign lfsr_step = inj_valid_i && mode_q == MODE_WEIGHT;

  route_lfsr #(.W(WW)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (lfsr_step),
    .rnd_o  (rnd)
  );

  route_table #(.IDW(IDW)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .raddr_i (inj_dst_i),
    .rdata_o (tbl_bit)
  );

  always_comb begin
    unique case (mode_q)
      MODE_TOGGLE: route_d = tog_q;
      MODE_WEIGHT: route_d = !(rnd < weight_q);
      MODE_PARITY: route_d = ^(src_id_i ^ inj_dst_i);
      MODE_TABLE:  route_d = tbl_bit;
      default:     route_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q   <= 1'b0;
      valid_q <= 1'b0;
      route_q <= 1'b0;
    end else begin
      valid_q <= inj_valid_i;
      if (inj_valid_i) route_q <= route_d;
      if (inj_valid_i && mode_q == MODE_TOGGLE) tog_q <= ~tog_q;
    end
  end

  assign hdr_valid_o = valid_q;
  assign hdr_route_o = route_q;
  assign hdr_vc_o    = route_q;

  route_hop #(.XW(XW), .YW(YW)) u_hop (
    .cur_i   (hop_cur_i),
    .dst_i   (hop_dst_i),
    .route_i (hop_route_i),
    .port_o  (hop_port)
  );

  assign hop_port_o = hop_port;

  // R2
  hdr_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_valid_i |=> hdr_valid_o);
  // R4
  xy_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_valid_i && mode_q == MODE_XY) |=> !hdr_route_o);
  // R6
  weight_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_valid_i && mode_q == MODE_WEIGHT && weight_q == '0) |=> hdr_route_o);
  // R1
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(mode_q) && $stable(weight_q));
  // R5
  toggle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inj_valid_i && mode_q == MODE_TOGGLE) |=> $stable(tog_q));

endmodule

// File: tb/mesh_route_sel_test.sv
module mesh_route_sel_test;

  localparam int XW = 2;
  localparam int YW = 2;
  localparam int WW = 8;
  localparam int IDW = XW + YW;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           cfg_we_i = 1'b0;
  logic [2:0]     cfg_mode_i = '0;
  logic [WW-1:0]  cfg_weight_i = '0;
  logic [IDW-1:0] src_id_i = '0;
  logic           tbl_we_i = 1'b0;
  logic [IDW-1:0] tbl_addr_i = '0;
  logic           tbl_data_i = 1'b0;
  logic           inj_valid_i = 1'b0;
  logic [IDW-1:0] inj_dst_i = '0;
  logic           hdr_valid_o, hdr_route_o, hdr_vc_o;
  logic [IDW-1:0] hop_cur_i = '0;
  logic [IDW-1:0] hop_dst_i = '0;
  logic           hop_route_i = 1'b0;
  logic [2:0]     hop_port_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] bm_lfsr = 8'h01;

  mesh_route_sel #(.XW(XW), .YW(YW), .WW(WW)) uut (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [2:0] m, input logic [7:0] w);
    cfg_we_i = 1'b1; cfg_mode_i = m; cfg_weight_i = w;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic inject(input logic [IDW-1:0] d, input string req, input int exp);
    inj_valid_i = 1'b1; inj_dst_i = d;
    @(negedge clk_i);
    inj_valid_i = 1'b0;
    check("R2", hdr_valid_o, 1);
    check(req, hdr_route_o, exp);
    check("R3", hdr_vc_o, exp);
  endtask

  task automatic test_reset();
    check("R2", hdr_valid_o, 0);
    check("R3", hdr_route_o, 0);
    check("R3", hdr_vc_o, 0);
    inject(4'd7, "R1", 0);
    @(negedge clk_i);
    check("R2", hdr_valid_o, 0);
    check("R2", hdr_route_o, 0);
  endtask

  task automatic test_xy_and_spare();
    set_cfg(3'd0, 8'd0);
    for (int d = 0; d < 16; d++) inject(d[IDW-1:0], "R4", 0);
    for (int m = 5; m < 8; m++) begin
      set_cfg(m[2:0], 8'd0);
      inject(4'd9, "R12", 0);
      inject(4'd3, "R12", 0);
    end
  endtask

  task automatic test_cfg_same_cycle();
    set_cfg(3'd0, 8'd0);
    // R1: mode write and injection on the same edge
    cfg_we_i = 1'b1; cfg_mode_i = 3'd1; inj_valid_i = 1'b1; inj_dst_i = 4'd5;
    @(negedge clk_i);
    cfg_we_i = 1'b0; inj_valid_i = 1'b0;
    check("R1", hdr_route_o, 0);
    inject(4'd5, "R5", 0);
    inject(4'd5, "R5", 1);
  endtask

  task automatic test_toggle();
    set_cfg(3'd1, 8'd0);
    // state is 0 again after the previous task's two packets
    inject(4'd1, "R5", 0);
    inject(4'd2, "R5", 1);
    inject(4'd3, "R5", 0);
    set_cfg(3'd0, 8'd0);
    inject(4'd4, "R5", 0);
    set_cfg(3'd1, 8'd0);
    inject(4'd4, "R5", 1);
    inject(4'd4, "R5", 0);
  endtask

  task automatic weighted_run(input logic [7:0] w, input int n);
    set_cfg(3'd2, w);
    for (int i = 0; i < n; i++) begin
      inject(4'd6, "R6", (bm_lfsr < w) ? 0 : 1);
      bm_lfsr = {bm_lfsr[6:0], bm_lfsr[7] ^ bm_lfsr[5] ^ bm_lfsr[4] ^ bm_lfsr[3]};
    end
  endtask

  task automatic test_weighted();
    weighted_run(8'd128, 40);
    weighted_run(8'd0, 10);
    weighted_run(8'd255, 20);
    set_cfg(3'd0, 8'd0);
    inject(4'd6, "R6", 0);
    weighted_run(8'd60, 20);
  endtask

  task automatic test_parity();
    set_cfg(3'd3, 8'd0);
    src_id_i = 4'd6;
    for (int d = 0; d < 16; d++) begin
      logic [IDW-1:0] x = 4'd6 ^ d[IDW-1:0];
      inject(d[IDW-1:0], "R7", x[0] ^ x[1] ^ x[2] ^ x[3]);
    end
    src_id_i = 4'd13;
    inject(4'd13, "R7", 0);
    inject(4'd12, "R7", 1);
  endtask

  task automatic test_table();
    set_cfg(3'd4, 8'd0);
    for (int d = 0; d < 16; d++) inject(d[IDW-1:0], "R8", 0);
    // R8: write and lookup of the same entry on one edge
    tbl_we_i = 1'b1; tbl_addr_i = 4'd5; tbl_data_i = 1'b1;
    inj_valid_i = 1'b1; inj_dst_i = 4'd5;
    @(negedge clk_i);
    tbl_we_i = 1'b0; inj_valid_i = 1'b0;
    check("R8", hdr_route_o, 0);
    inject(4'd5, "R8", 1);
    inject(4'd4, "R8", 0);
    tbl_we_i = 1'b1; tbl_addr_i = 4'd15; tbl_data_i = 1'b1;
    @(negedge clk_i);
    tbl_addr_i = 4'd5; tbl_data_i = 1'b0;
    @(negedge clk_i);
    tbl_we_i = 1'b0;
    inject(4'd15, "R8", 1);
    inject(4'd5, "R8", 0);
  endtask

  task automatic test_hop();
    for (int c = 0; c < 16; c++)
      for (int d = 0; d < 16; d++)
        for (int r = 0; r < 2; r++) begin
          int cx = c % 4, cy = c / 4, dx = d % 4, dy = d / 4;
          int ex = (dx > cx) ? 1 : 2;
          int ey = (dy > cy) ? 3 : 4;
          int exp;
          string req;
          if (c == d)      begin exp = 0; req = "R11"; end
          else if (r == 0) begin exp = (cx != dx) ? ex : ey; req = "R9"; end
          else             begin exp = (cy != dy) ? ey : ex; req = "R10"; end
          hop_cur_i = c[IDW-1:0]; hop_dst_i = d[IDW-1:0]; hop_route_i = r[0];
          #1;
          check(req, hop_port_o, exp);
        end
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    test_reset();
    test_xy_and_spare();
    test_cfg_same_cycle();
    test_toggle();
    test_weighted();
    test_parity();
    test_table();
    test_hop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule